// File: doc/BRIEF.md
# Sixteen-Bit Timer with Input Capture and Byte-Wide Register Access

This block is a 16-bit timer peripheral that sits on an 8-bit processor bus. A counter advances once per clock while the run bit is set. Two compare registers flag the cycles in which the counter equals them. A capture register records the counter when a rising edge arrives on the selected event input. In one mode the counter restarts from zero after it reaches the value in the capture register instead of after 0xFFFF.

Each 16-bit register appears as a low-byte and a high-byte address. One shared 8-bit holding latch makes the two byte accesses behave as a single access. Reading a low byte copies the matching high byte into the latch, and the high-byte address then returns the latch. Writing a high byte fills only the latch, and the next low-byte write stores both bytes together. Four event flags are combined with an enable mask and a global enable input into one interrupt request.

Address map (4-bit byte address): 0/1 counter low/high, 2/3 capture low/high, 4/5 compare A low/high, 6/7 compare B low/high, 8 mask, 9 flags, 10 control. Flag and mask bits share positions: bit 5 capture, bit 2 compare B, bit 1 compare A, bit 0 overflow. Control: bit 0 run, bit 1 capture-as-top mode, bit 2 event source (0 = pin, 1 = comparator input).

Top module: `tcu_timer`

## Requirements
- R1: After reset the counter, capture, compare, mask, flag and control registers read zero and `irq` is low.
- R2: With control bit 0 set the counter gains one per clock; with it clear the counter holds. A counter write takes priority over counting.
- R3: With control bit 1 clear the counter goes from 0xFFFF to 0x0000 and sets flag bit 0.
- R4: With control bit 1 set the counter goes from the capture register value to 0x0000 and sets flag bit 0.
- R5: A rising edge on the selected event input passes a two-stage synchronizer. On the third rising clock edge after the input is first sampled high, the capture register takes the counter value and flag bit 5 is set.
- R6: Control bit 2 selects the event source: 0 uses `cap_pin`, 1 uses `cmp_in`. Edges on the unselected input have no effect.
- R7: While running, a counter value equal to compare A sets flag bit 1, and one equal to compare B sets flag bit 2.
- R8: Reading any low-byte address returns the live low byte and loads the holding latch with the high byte of the same value. Reading any high-byte address returns the latch.
- R9: Writing a high-byte address changes only the holding latch. Writing the low byte then stores {latch, data} into that 16-bit register in one cycle.
- R10: Only mask bits 5, 2, 1 and 0 can be written. Bits 7, 6, 4 and 3 of the mask and flag registers always read zero.
- R11: Writing a one to a flag bit clears it. A hardware set in the same cycle wins over the clear.
- R12: `irq` is high exactly when `gie` is high and some flag bit is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| cap_pin | input | 1 | External capture event pin (asynchronous) |
| cmp_in | input | 1 | Comparator event input (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle and that each access lasts exactly one cycle. The capture-register assertion also assumes that the event inputs change no faster than the synchronizer can follow. The bench drives each strobe for a single clock, changed at the falling edge, and never overlaps a read with a write. It holds each event level for several cycles. Both event inputs are held low whenever the source bit changes, so switching the source cannot itself produce an edge.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO  = 4'h0,
    A_CNT_HI  = 4'h1,
    A_CAP_LO  = 4'h2,
    A_CAP_HI  = 4'h3,
    A_CMPA_LO = 4'h4,
    A_CMPA_HI = 4'h5,
    A_CMPB_LO = 4'h6,
    A_CMPB_HI = 4'h7,
    A_MASK    = 4'h8,
    A_FLAG    = 4'h9,
    A_CTRL    = 4'hA
  } reg_addr_e;

  // bit positions shared by flag and mask registers
  localparam int FB_OVF  = 0;
  localparam int FB_CMPA = 1;
  localparam int FB_CMPB = 2;
  localparam int FB_CAP  = 5;
  localparam logic [7:0] EVT_BITS = 8'h27;

  // control bits
  localparam int CB_RUN = 0;
  localparam int CB_TOP = 1;
  localparam int CB_SRC = 2;
  localparam int CTRL_W = 3;

  // wide register slots, selected by addr[2:1]
  localparam int WS_CNT  = 0;
  localparam int WS_CAP  = 1;
  localparam int WS_CMPA = 2;
  localparam int WS_CMPB = 3;
endpackage

// File: rtl/tcu_edge_sync.sv
module tcu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic strobe
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign strobe = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R5: edge detector yields single-cycle pulses
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] top_val,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;

  assign at_top = (cnt_q == top_val);
  assign wrap   = run & ~load & at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (run)    cnt_d = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: running counter steps by one below its top
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != top_val) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2: stopped counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
  // R4: at top the counter restarts from zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
endmodule

// File: rtl/tcu_timer.sv
module tcu_timer
  import tcu_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cap_pin,
  input  logic          cmp_in,
  input  logic          gie,
  output logic          irq
);
  localparam int W     = 2 * DW;
  localparam int SLOTS = 4;

  logic [W-1:0]      cnt, cap_q, cap_d, cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic [W-1:0]      wide_val [SLOTS];
  logic [W-1:0]      sel_val, commit_val, top_val;
  logic [DW-1:0]     tmp_q, tmp_d, mask_q, mask_d, flag_q, flag_d;
  logic [DW-1:0]     hw_set, flag_clr;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              is_wide, is_hi, wr_lo, wr_hi, rd_lo;
  logic [1:0]        slot;
  logic              cap_src, cap_stb, wrap, running, hit_a, hit_b, load_cnt;

  // bus decode
  assign is_wide = ~bus_addr[3];
  assign is_hi   = bus_addr[0];
  assign slot    = bus_addr[2:1];
  assign wr_lo   = bus_wr & is_wide & ~is_hi;
  assign wr_hi   = bus_wr & is_wide &  is_hi;
  assign rd_lo   = bus_rd & is_wide & ~is_hi;

  assign wide_val[WS_CNT]  = cnt;
  assign wide_val[WS_CAP]  = cap_q;
  assign wide_val[WS_CMPA] = cmpa_q;
  assign wide_val[WS_CMPB] = cmpb_q;
  assign sel_val    = wide_val[slot];
  assign commit_val = {tmp_q, bus_wdata};

  // event source and synchronizer
  assign cap_src = ctrl_q[CB_SRC] ? cmp_in : cap_pin;

  tcu_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_src), .strobe(cap_stb)
  );

  // counter
  assign running  = ctrl_q[CB_RUN];
  assign top_val  = ctrl_q[CB_TOP] ? cap_q : {W{1'b1}};
  assign load_cnt = wr_lo & (slot == 2'(WS_CNT));

  tcu_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running), .top_val(top_val),
    .load(load_cnt), .load_val(commit_val), .cnt(cnt), .wrap(wrap)
  );

  assign hit_a = running & (cnt == cmpa_q);
  assign hit_b = running & (cnt == cmpb_q);

  always_comb begin
    hw_set          = '0;
    hw_set[FB_OVF]  = wrap;
    hw_set[FB_CMPA] = hit_a;
    hw_set[FB_CMPB] = hit_b;
    hw_set[FB_CAP]  = cap_stb;
  end

  // next state
  always_comb begin
    tmp_d  = tmp_q;
    cap_d  = cap_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    mask_d = mask_q;
    ctrl_d = ctrl_q;
    if (wr_hi)      tmp_d = bus_wdata;
    else if (rd_lo) tmp_d = sel_val[W-1:DW];
    if (cap_stb)                              cap_d  = cnt;
    else if (wr_lo && slot == 2'(WS_CAP))     cap_d  = commit_val;
    if (wr_lo && slot == 2'(WS_CMPA))         cmpa_d = commit_val;
    if (wr_lo && slot == 2'(WS_CMPB))         cmpb_d = commit_val;
    if (bus_wr && bus_addr == A_MASK)         mask_d = bus_wdata & EVT_BITS;
    if (bus_wr && bus_addr == A_CTRL)         ctrl_d = bus_wdata[CTRL_W-1:0];
    flag_clr = (bus_wr && bus_addr == A_FLAG) ? (bus_wdata & EVT_BITS) : '0;
    flag_d   = (flag_q & ~flag_clr) | hw_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q  <= '0;
      cap_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
      ctrl_q <= '0;
    end else begin
      tmp_q  <= tmp_d;
      cap_q  <= cap_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
      ctrl_q <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_wide)                    bus_rdata = is_hi ? tmp_q : sel_val[DW-1:0];
      else if (bus_addr == A_MASK)    bus_rdata = mask_q;
      else if (bus_addr == A_FLAG)    bus_rdata = flag_q;
      else if (bus_addr == A_CTRL)    bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
    end
  end

  assign irq = gie & |(flag_q & mask_q);

  // R5: capture strobe records the counter of that cycle
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> cap_q == $past(cnt));
  // R11: hardware set survives a simultaneous clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> flag_q[FB_CAP]);
  // R8: low-byte read snapshots the high byte
  p_snapshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> tmp_q == $past(sel_val[W-1:DW]));
  // R9: high-byte write leaves the wide registers untouched
  p_hi_only_tmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ($stable(cmpa_q) && $stable(cmpb_q)));
endmodule

// File: tb/tcu_timer_bench.sv
module tcu_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0;
  logic       cmp_in = 1'b0;
  logic       gie = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcu_timer u_tcu_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cmp_in(cmp_in), .gie(gie), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  // run for k idle cycles; counter advances k+1 times
  task automatic run_for(input logic [7:0] ctrl, input int k);
    wr(4'hA, ctrl);
    repeat (k) @(negedge clk);
    wr(4'hA, ctrl & 8'hFE);
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] b;
    rd16(4'h0, v); chk("R1 counter", v, 16'h0);
    rd16(4'h2, v); chk("R1 capture", v, 16'h0);
    rd16(4'h4, v); chk("R1 compare A", v, 16'h0);
    rd(4'h8, b);   chk("R1 mask", {8'h0, b}, 16'h0);
    rd(4'h9, b);   chk("R1 flags", {8'h0, b}, 16'h0);
    rd(4'hA, b);   chk("R1 control", {8'h0, b}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_mask;
    logic [7:0] b;
    wr(4'h8, 8'hFF);
    rd(4'h8, b); chk("R10 mask writable bits", {8'h0, b}, 16'h0027);
    wr(4'h8, 8'h00);
  endtask

  task automatic t_atomic_write;
    logic [7:0] b;
    wr16(4'h4, 16'h0010);
    wr(4'h5, 8'h77);
    rd(4'h4, b); chk("R9 low unchanged by high write", {8'h0, b}, 16'h0010);
    rd(4'h5, b); chk("R9 high not committed", {8'h0, b}, 16'h0000);
    wr(4'h5, 8'h77);
    wr(4'h4, 8'h20);
    rd(4'h4, b); chk("R9 committed low", {8'h0, b}, 16'h0020);
    rd(4'h5, b); chk("R9 committed high", {8'h0, b}, 16'h0077);
  endtask

  task automatic t_atomic_read;
    logic [7:0] b;
    wr16(4'h0, 16'h12FF);
    rd(4'h0, b);
    rd(4'h3, b); chk("R8 shared latch via other high address", {8'h0, b}, 16'h0012);
    wr16(4'h0, 16'h00FF);
    wr(4'hA, 8'h01);
    rd(4'h0, b); chk("R8 live low byte", {8'h0, b}, 16'h00FF);
    rd(4'h1, b); chk("R8 high from snapshot", {8'h0, b}, 16'h0000);
    wr(4'hA, 8'h00);
    rd(4'h0, b); chk("R8 low after stop", {8'h0, b}, 16'h0002);
    rd(4'h1, b); chk("R8 high after stop", {8'h0, b}, 16'h0001);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr16(4'h0, 16'h1234);
    run_for(8'h01, 9);
    rd16(4'h0, v); chk("R2 count steps", v, 16'h123E);
    repeat (5) @(negedge clk);
    rd16(4'h0, v); chk("R2 hold when stopped", v, 16'h123E);
  endtask

  task automatic t_compare;
    logic [15:0] v; logic [7:0] b;
    wr16(4'h4, 16'h0010);
    wr16(4'h6, 16'h0012);
    wr16(4'h0, 16'h000E);
    wr(4'h9, 8'hFF);
    run_for(8'h01, 3);
    rd16(4'h0, v); chk("R7 count", v, 16'h0012);
    rd(4'h9, b);   chk("R7 compare A flag", {8'h0, b}, 16'h0002);
    wr(4'h9, 8'hFF);
    run_for(8'h01, 0);
    rd(4'h9, b);   chk("R7 compare B flag", {8'h0, b}, 16'h0004);
  endtask

  task automatic t_wrap;
    logic [15:0] v; logic [7:0] b;
    wr16(4'h0, 16'hFFFE);
    wr(4'h9, 8'hFF);
    run_for(8'h01, 1);
    rd16(4'h0, v); chk("R3 wrap to zero", v, 16'h0000);
    rd(4'h9, b);   chk("R3 overflow flag", {8'h0, b}, 16'h0001);
  endtask

  task automatic t_top;
    logic [15:0] v; logic [7:0] b;
    wr16(4'h2, 16'h0005);
    wr16(4'h0, 16'h0003);
    wr(4'h9, 8'hFF);
    run_for(8'h03, 3);
    rd16(4'h0, v); chk("R4 wrap at capture value", v, 16'h0001);
    rd(4'h9, b);   chk("R4 overflow flag", {8'h0, b & 8'h01}, 16'h0001);
  endtask

  task automatic t_capture;
    logic [15:0] v; logic [7:0] b;
    wr(4'hA, 8'h00);
    wr16(4'h0, 16'h4321);
    wr(4'h9, 8'hFF);
    cap_pin = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd(4'h2, b); chk("R5 not yet captured", {8'h0, b}, 16'h0005);
    rd16(4'h2, v); chk("R5 captured value", v, 16'h4321);
    rd(4'h9, b);   chk("R5 capture flag", {8'h0, b}, 16'h0020);
    repeat (4) @(negedge clk);
    cap_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_source;
    logic [15:0] v; logic [7:0] b;
    wr(4'hA, 8'h04);
    wr16(4'h0, 16'h5555);
    wr(4'h9, 8'hFF);
    cap_pin = 1'b1; repeat (6) @(negedge clk);
    cap_pin = 1'b0; repeat (6) @(negedge clk);
    rd16(4'h2, v); chk("R6 pin ignored when comparator selected", v, 16'h4321);
    rd(4'h9, b);   chk("R6 no flag from unselected pin", {8'h0, b}, 16'h0000);
    cmp_in = 1'b1; repeat (6) @(negedge clk);
    rd16(4'h2, v); chk("R6 comparator capture", v, 16'h5555);
    cmp_in = 1'b0; repeat (6) @(negedge clk);
    wr(4'hA, 8'h00);
  endtask

  task automatic t_irq;
    wr(4'h8, 8'h20);
    gie = 1'b0; #1;
    chk("R12 irq blocked by gie", {15'h0, irq}, 16'h0);
    gie = 1'b1; #1;
    chk("R12 irq asserted", {15'h0, irq}, 16'h1);
    @(negedge clk);
    wr(4'h8, 8'h01);
    chk("R12 irq masked", {15'h0, irq}, 16'h0);
    wr(4'h9, 8'hFF);
    wr(4'h8, 8'h20);
    chk("R12 irq after clear", {15'h0, irq}, 16'h0);
    gie = 1'b0;
  endtask

  task automatic t_priority;
    logic [7:0] b;
    wr16(4'h4, 16'h0010);
    wr16(4'h0, 16'h000F);
    wr(4'h9, 8'hFF);
    wr(4'hA, 8'h01);
    @(negedge clk);
    wr(4'h9, 8'h02);
    wr(4'hA, 8'h00);
    rd(4'h9, b); chk("R11 set wins over clear", {8'h0, b & 8'h02}, 16'h0002);
    wr(4'h9, 8'h02);
    rd(4'h9, b); chk("R11 write one clears", {8'h0, b & 8'h02}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_atomic_write;
    t_atomic_read;
    t_count;
    t_compare;
    t_wrap;
    t_top;
    t_capture;
    t_source;
    t_irq;
    t_priority;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule